// File: doc/BRIEF.md
# Multi-Layer Associative Pattern Matcher

This block is a small content-addressable bank for track finding. Each stored pattern holds one 16-bit word per detector layer, six layers in all. Hits reach the block on six independent buses, one per layer, with no fixed timing between the buses. Every pattern compares its word for each layer with that layer's bus on every clock and remembers, in a sticky flag, each layer that has ever agreed during the current event. A pattern is declared matched when enough of its layers have agreed. The count needed is a programmable threshold, and the declaration can also require one chosen layer to be among those that agreed.

The two upper bits of each 18-bit bus are checked once for the whole bank against a configured 2-bit value. Only buses that pass this check are presented to the patterns. An end-of-event strobe clears every flag. In the twelve-layer mode, each even/odd pair of patterns acts as one twelve-word pattern. Bus bit 17 then chooses which half of the pair a hit belongs to, and only bit 16 is checked against the configured value.

A two-state event controller tracks whether an event is open. `EV_IDLE` moves to `EV_ACTIVE` on any accepted hit (transition *open*). `EV_ACTIVE` returns to `EV_IDLE` on the end-of-event strobe (transition *close*). The strobe has priority, so a cycle that carries both an accepted hit and the strobe remains in, or returns to, `EV_IDLE`. Pattern writes take effect only in `EV_IDLE`.

Top module: `amm_bank`

## Requirements
- R1: While and after reset, every layer flag and every match bit is 0, the event controller is in `EV_IDLE`, and every stored word is 0.
- R2: A bus hit is accepted only when its valid strobe is 1 and its bits [17:16] equal `cfg_mask` (six-layer mode). An accepted hit sets the layer-L flag of every pattern whose layer-L word equals bus bits [15:0]. A hit that is not valid, or whose upper bits disagree, changes nothing.
- R3: Layer flags are sticky. Hits arriving on different cycles and buses accumulate until end of event.
- R4: In six-layer mode, bit i of `match_vec` sets after the same clock edge that brings pattern i's count of flagged layers to at least `cfg_thresh`.
- R5: When `cfg_req_en` is 1, a pattern matches only if the layer numbered `cfg_req_layer` is flagged. Layers are 0 to 5 in six-layer mode and 0 to 11 in twelve-layer mode, where layers 6 to 11 are the odd pattern's layers 0 to 5.
- R6: A match bit stays set until end of event. The `end_event` edge clears all flags and match bits, and hits presented in that same cycle are discarded.
- R7: `wr_en` stores `wr_words` (layer L in bits [16L+15:16L]) at `wr_addr` only while the controller is in `EV_IDLE`. A write during an open event is ignored.
- R8: The controller enters `EV_ACTIVE` on any accepted hit and leaves it only on `end_event`.
- R9: With `cfg_mode12` set, bus bit 17 selects the even (0) or odd (1) pattern of each pair, and bit 16 must equal `cfg_mask[0]`. The pair's twelve flags are counted together, the match appears on the even bit, and the odd bit stays 0.
- R10: A pattern with no flagged layer never matches, so a threshold of 0 behaves as a threshold of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | AW | Pattern index to write |
| wr_words | input | 96 | Six 16-bit layer words, layer 0 lowest |
| hit_valid | input | 6 | Per-layer hit strobe |
| hit_data | input | 108 | Six 18-bit hit buses, layer 0 lowest |
| end_event | input | 1 | Clears all flags and closes the event |
| cfg_mode12 | input | 1 | Pairs patterns into twelve-layer patterns |
| cfg_mask | input | 2 | Required value of the bus upper bits |
| cfg_thresh | input | 4 | Minimum count of flagged layers |
| cfg_req_en | input | 1 | Enables the required-layer condition |
| cfg_req_layer | input | 4 | Index of the required layer |
| match_vec | output | NPAT | Sticky per-pattern match flags |

## Verification
The assertions assume that configuration inputs change only in a cycle that also carries `end_event`, or before any hit. This keeps a mode or threshold change from altering the meaning of flags already collected within an event. The stimulus follows this rule: directed phases set the configuration between events, and the random phase redraws the configuration only in its end-of-event cycles. The assertions also assume that `wr_addr` is in range. The bench uses a power-of-two pattern count, so every address is in range.

// File: rtl/amm_pkg.sv
package amm_pkg;

    localparam int LAYERS = 6;
    localparam int WORD_W = 16;
    localparam int BUS_W  = WORD_W + 2;
    localparam int CNT_W  = 4;

    typedef enum logic [0:0] {
        EV_IDLE   = 1'b0,
        EV_ACTIVE = 1'b1
    } ev_state_t;

    // Count flagged layers of a (possibly paired) pattern and apply the
    // threshold and the optional required-layer condition.
    function automatic logic amm_qualify(
        input logic [2*LAYERS-1:0] flags,
        input logic [CNT_W-1:0]    thresh,
        input logic                req_en,
        input logic [CNT_W-1:0]    req_layer
    );
        logic [CNT_W-1:0] cnt;
        logic             req_hit;
        cnt     = '0;
        req_hit = 1'b0;
        for (int i = 0; i < 2*LAYERS; i++) begin
            cnt = cnt + CNT_W'(flags[i]);
            if (req_layer == CNT_W'(i)) req_hit = flags[i];
        end
        return (cnt >= thresh) && (cnt != '0) && (!req_en || req_hit);
    endfunction

endpackage

// File: rtl/amm_hit_filter.sv
module amm_hit_filter
    import amm_pkg::*;
(
    input  logic [LAYERS-1:0]        hit_valid,
    input  logic [LAYERS*BUS_W-1:0]  hit_data,
    input  logic                     mode12,
    input  logic [1:0]               mask,
    output logic [LAYERS-1:0]        acc,
    output logic [LAYERS*WORD_W-1:0] word_flat,
    output logic [LAYERS-1:0]        sel
);

    for (genvar l = 0; l < LAYERS; l++) begin : g_bus
        logic [BUS_W-1:0] bus;
        logic             hi_ok;
        assign bus   = hit_data[l*BUS_W +: BUS_W];
        assign hi_ok = mode12 ? (bus[WORD_W] == mask[0])
                              : (bus[BUS_W-1:WORD_W] == mask);
        assign acc[l]                       = hit_valid[l] && hi_ok;
        assign word_flat[l*WORD_W +: WORD_W] = bus[WORD_W-1:0];
        assign sel[l]                       = bus[BUS_W-1];
    end

endmodule

// File: rtl/amm_event_fsm.sv
module amm_event_fsm
    import amm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_hit,
    input  logic end_event,
    output logic busy
);

    ev_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:   if (!end_event && any_hit) state_d = EV_ACTIVE;
            EV_ACTIVE: if (end_event)             state_d = EV_IDLE;
            default:   state_d = EV_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == EV_ACTIVE);
    end

    // R8
    event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_ACTIVE && !end_event) |=> (state_q == EV_ACTIVE));

    // R8
    event_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_IDLE && any_hit && !end_event) |=> (state_q == EV_ACTIVE));

endmodule

// File: rtl/amm_pattern_cell.sv
module amm_pattern_cell
    import amm_pkg::*;
#(
    parameter logic PAIR_SIDE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_sel,
    input  logic                     busy,
    input  logic [LAYERS*WORD_W-1:0] wr_words,
    input  logic [LAYERS-1:0]        acc,
    input  logic [LAYERS*WORD_W-1:0] word_flat,
    input  logic [LAYERS-1:0]        sel,
    input  logic                     mode12,
    input  logic                     end_event,
    output logic [LAYERS-1:0]        flags_nxt
);

    logic [LAYERS*WORD_W-1:0] store_q;
    logic [LAYERS-1:0]        flags_q;
    logic [LAYERS-1:0]        hit_now;

    for (genvar l = 0; l < LAYERS; l++) begin : g_cmp
        assign hit_now[l] = acc[l]
                         && (!mode12 || (sel[l] == PAIR_SIDE))
                         && (word_flat[l*WORD_W +: WORD_W] == store_q[l*WORD_W +: WORD_W]);
    end

    assign flags_nxt = end_event ? '0 : (flags_q | hit_now);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
            flags_q <= '0;
        end else begin
            flags_q <= flags_nxt;
            if (wr_sel && !busy) store_q <= wr_words;
        end
    end

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_event |=> ((($past(flags_q)) & ~flags_q) == '0));

    // R7
    write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && busy) |=> $stable(store_q));

endmodule

// File: rtl/amm_bank.sv
module amm_bank
    import amm_pkg::*;
#(
    parameter  int NPAT = 32,
    localparam int AW   = (NPAT > 1) ? $clog2(NPAT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [LAYERS*WORD_W-1:0] wr_words,
    input  logic [LAYERS-1:0]        hit_valid,
    input  logic [LAYERS*BUS_W-1:0]  hit_data,
    input  logic                     end_event,
    input  logic                     cfg_mode12,
    input  logic [1:0]               cfg_mask,
    input  logic [CNT_W-1:0]         cfg_thresh,
    input  logic                     cfg_req_en,
    input  logic [CNT_W-1:0]         cfg_req_layer,
    output logic [NPAT-1:0]          match_vec
);

    localparam int NPAIR = NPAT / 2;

    logic [LAYERS-1:0]        acc;
    logic [LAYERS*WORD_W-1:0] word_flat;
    logic [LAYERS-1:0]        sel;
    logic                     busy;
    logic [LAYERS-1:0]        fnx [NPAT];
    logic [NPAT-1:0]          match_q, match_d;

    amm_hit_filter u_filt (
        .hit_valid (hit_valid),
        .hit_data  (hit_data),
        .mode12    (cfg_mode12),
        .mask      (cfg_mask),
        .acc       (acc),
        .word_flat (word_flat),
        .sel       (sel)
    );

    amm_event_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_hit   (|acc),
        .end_event (end_event),
        .busy      (busy)
    );

    for (genvar i = 0; i < NPAT; i++) begin : g_pat
        amm_pattern_cell #(.PAIR_SIDE(1'(i % 2))) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (wr_en && (wr_addr == AW'(i))),
            .busy      (busy),
            .wr_words  (wr_words),
            .acc       (acc),
            .word_flat (word_flat),
            .sel       (sel),
            .mode12    (cfg_mode12),
            .end_event (end_event),
            .flags_nxt (fnx[i])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic cond_even, cond_odd;
        assign cond_even = cfg_mode12
            ? amm_qualify({fnx[2*p+1], fnx[2*p]}, cfg_thresh, cfg_req_en, cfg_req_layer)
            : amm_qualify({{LAYERS{1'b0}}, fnx[2*p]}, cfg_thresh, cfg_req_en, cfg_req_layer);
        assign cond_odd = !cfg_mode12
            && amm_qualify({{LAYERS{1'b0}}, fnx[2*p+1]}, cfg_thresh, cfg_req_en, cfg_req_layer);
        assign match_d[2*p]   = !end_event && (match_q[2*p]   || cond_even);
        assign match_d[2*p+1] = !end_event && (match_q[2*p+1] || cond_odd);
    end

    if (NPAT % 2 != 0) begin : g_tail
        assign match_d[NPAT-1] = !end_event && (match_q[NPAT-1]
            || (!cfg_mode12 && amm_qualify({{LAYERS{1'b0}}, fnx[NPAT-1]},
                                           cfg_thresh, cfg_req_en, cfg_req_layer)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= match_d;
    end

    assign match_vec = match_q;

    // R6
    match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_event |=> (match_vec == '0));

    // R6
    match_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_event |=> ((($past(match_vec)) & ~match_vec) == '0));

    // R10
    match_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_event || !(|acc)) |=> ($past(match_vec) == match_vec || match_vec == '0));

endmodule

// File: tb/sim_amm_bank.sv
`timescale 1ns/1ps
module sim_amm_bank;

    localparam int NP = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [95:0]   wr_words;
    logic [5:0]    hv;
    logic [17:0]   hd [6];
    logic [107:0]  hit_data;
    logic          eoe;
    logic          mode12;
    logic [1:0]    mask;
    logic [3:0]    thr;
    logic          req_en;
    logic [3:0]    req_layer;
    logic [NP-1:0] match_vec;

    always #4 clk = ~clk;

    always_comb begin
        for (int l = 0; l < 6; l++) hit_data[l*18 +: 18] = hd[l];
    end

    amm_bank #(.NPAT(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_words(wr_words), .hit_valid(hv), .hit_data(hit_data),
        .end_event(eoe), .cfg_mode12(mode12), .cfg_mask(mask),
        .cfg_thresh(thr), .cfg_req_en(req_en), .cfg_req_layer(req_layer),
        .match_vec(match_vec)
    );

    // reference model state
    logic [15:0] mpat [NP][6];
    bit          mfl  [NP][6];
    bit          mm   [NP];
    bit          mact;
    int          vectors = 0;
    int          fails   = 0;
    string       tg = "R1";

    function automatic logic [15:0] pw(int p, int l);
        return 16'(32'hA000 + p * 16 + l);
    endfunction

    task automatic model_update();
        bit acc [6];
        bit any;
        int cnt;
        bit rq;
        bit b;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                mm[i] = 0;
                for (int l = 0; l < 6; l++) begin mfl[i][l] = 0; mpat[i][l] = '0; end
            end
            mact = 0;
            return;
        end
        any = 0;
        for (int l = 0; l < 6; l++) begin
            acc[l] = hv[l] && (mode12 ? (hd[l][16] == mask[0]) : (hd[l][17:16] == mask));
            any |= acc[l];
        end
        if (eoe) begin
            for (int i = 0; i < NP; i++) begin
                mm[i] = 0;
                for (int l = 0; l < 6; l++) mfl[i][l] = 0;
            end
        end else begin
            for (int i = 0; i < NP; i++)
                for (int l = 0; l < 6; l++)
                    if (acc[l] && (!mode12 || hd[l][17] == 1'(i % 2)) && hd[l][15:0] == mpat[i][l])
                        mfl[i][l] = 1;
        end
        if (wr_en && !mact)
            for (int l = 0; l < 6; l++) mpat[wr_addr][l] = wr_words[l*16 +: 16];
        if (eoe) mact = 0;
        else if (any) mact = 1;
        if (!eoe) begin
            for (int i = 0; i < NP; i++) begin
                if (mode12 && (i % 2) == 1) continue;
                cnt = 0; rq = 0;
                for (int k = 0; k < (mode12 ? 12 : 6); k++) begin
                    b = (k < 6) ? mfl[i][k] : mfl[i+1][k-6];
                    cnt += int'(b);
                    if (k == int'(req_layer)) rq = b;
                end
                if (cnt > 0 && cnt >= int'(thr) && (!req_en || rq)) mm[i] = 1;
            end
        end
    endtask

    task automatic step();
        logic [NP-1:0] exp;
        @(posedge clk);
        #1;
        model_update();
        for (int i = 0; i < NP; i++) exp[i] = mm[i];
        vectors++;
        if (match_vec !== exp) begin
            fails++;
            $display("FAIL %s: match_vec actual %b expected %b at %0t", tg, match_vec, exp, $time);
        end
    endtask

    task automatic clear_in();
        hv = '0; wr_en = 0; eoe = 0;
        for (int l = 0; l < 6; l++) hd[l] = '0;
    endtask

    task automatic hit(int l, logic [17:0] d);
        hv[l] = 1'b1; hd[l] = d;
    endtask

    task automatic end_ev();
        eoe = 1; step(); clear_in();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        clear_in();
        wr_addr = '0; wr_words = '0;
        mode12 = 0; mask = 2'b01; thr = 4'd6; req_en = 0; req_layer = '0;
        rst_n = 0;
        tg = "R1";
        repeat (3) step();
        rst_n = 1;
        step();

        // R7: load all patterns while idle
        tg = "R7";
        for (int p = 0; p < NP; p++) begin
            wr_en = 1; wr_addr = AW'(p);
            for (int l = 0; l < 6; l++) wr_words[l*16 +: 16] = pw(p, l);
            step();
        end
        clear_in();
        step();

        // R2: invalid and mask-mismatched hits are ignored
        tg = "R2";
        hd[0] = {2'b01, pw(3, 0)}; step(); clear_in();
        hit(1, {2'b10, pw(3, 1)}); step(); clear_in();
        hit(2, {2'b00, pw(3, 2)}); step(); clear_in();
        // R3: accumulate pattern 3 over several cycles, out of order
        tg = "R3";
        hit(5, {2'b01, pw(3, 5)}); hit(0, {2'b01, pw(3, 0)}); hit(3, {2'b01, pw(3, 3)});
        step(); clear_in();
        hit(1, {2'b01, pw(3, 1)}); hit(2, {2'b01, pw(6, 2)}); step(); clear_in();
        step();
        tg = "R4";
        hit(4, {2'b01, pw(3, 4)}); hit(2, {2'b01, pw(3, 2)}); step(); clear_in();
        tg = "R6";
        repeat (3) step();
        end_ev();
        step();

        // R4: threshold 5 of 6
        tg = "R4";
        thr = 4'd5;
        for (int l = 0; l < 5; l++) hit(l, {2'b01, pw(5, l)});
        step(); clear_in();
        for (int l = 0; l < 4; l++) hit(l, {2'b01, pw(6, l)});
        step(); clear_in();
        end_ev();

        // R5: required layer 2
        tg = "R5";
        req_en = 1; req_layer = 4'd2;
        for (int l = 0; l < 6; l++) if (l != 2) hit(l, {2'b01, pw(1, l)});
        step(); clear_in();
        step();
        hit(2, {2'b01, pw(1, 2)}); step(); clear_in();
        end_ev();
        req_en = 0;

        // R8/R7: write during open event is ignored
        tg = "R8";
        thr = 4'd6;
        hit(0, {2'b01, pw(0, 0)}); step(); clear_in();
        tg = "R7";
        wr_en = 1; wr_addr = 3'd0; wr_words = {96{1'b1}}; step(); clear_in();
        end_ev();
        for (int l = 0; l < 6; l++) hit(l, {2'b01, pw(0, l)});
        step(); clear_in();
        end_ev();
        wr_en = 1; wr_addr = 3'd7;
        for (int l = 0; l < 6; l++) wr_words[l*16 +: 16] = 16'(16'h5000 + l);
        step(); clear_in();
        for (int l = 0; l < 6; l++) hit(l, {2'b01, 16'(16'h5000 + l)});
        step(); clear_in();
        end_ev();

        // R6: hits in the end-of-event cycle are discarded
        tg = "R6";
        for (int l = 0; l < 6; l++) hit(l, {2'b01, pw(2, l)});
        eoe = 1; step(); clear_in();
        step();
        end_ev();

        // R9: paired twelve-layer mode
        tg = "R9";
        mode12 = 1; thr = 4'd10;
        for (int l = 0; l < 6; l++) hit(l, {2'b01, pw(4, l)});
        step(); clear_in();
        for (int l = 0; l < 4; l++) hit(l, {2'b01, pw(5, l)});
        step(); clear_in();
        hit(4, {2'b01, pw(5, 4)}); step(); clear_in();
        step(); clear_in();
        for (int l = 0; l < 6; l++) hit(l, {2'b11, pw(5, l)});
        step(); clear_in();
        end_ev();
        req_en = 1; req_layer = 4'd9;
        for (int l = 0; l < 6; l++) hit(l, {2'b01, pw(2, l)});
        step(); clear_in();
        for (int l = 0; l < 6; l++) if (l != 3) hit(l, {2'b11, pw(3, l)});
        step(); clear_in();
        hit(3, {2'b11, pw(3, 3)}); step(); clear_in();
        end_ev();
        req_en = 0; mode12 = 0;

        // R10: threshold zero still needs a flagged layer
        tg = "R10";
        thr = 4'd0;
        step(); step();
        hit(0, {2'b01, pw(3, 0)}); step(); clear_in();
        end_ev();

        // R4: random traffic, configuration redrawn only at end of event
        tg = "R4";
        thr = 4'd4;
        for (int c = 0; c < 800; c++) begin
            if ((c % 13) == 12) begin
                eoe = 1;
                thr = 4'($urandom_range(1, 6));
                req_en = 1'($urandom_range(0, 3) == 0);
                req_layer = 4'($urandom_range(0, 7));
                mode12 = 1'($urandom_range(0, 2) == 0);
                if (mode12) thr = 4'($urandom_range(6, 12));
            end
            for (int l = 0; l < 6; l++) begin
                if ($urandom_range(0, 1) == 1) begin
                    int p;
                    logic [1:0] hi;
                    p = int'($urandom_range(0, NP - 1));
                    hi = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3))
                                                     : {1'(p % 2), 1'b1};
                    if (!mode12 && $urandom_range(0, 7) != 0) hi = 2'b01;
                    hit(l, {hi, mpat[p][l]});
                end
            end
            step(); clear_in();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule